// File: doc/BRIEF.md
# Dual-Bridge Enable and Fault Supervisor

This block sits between two full-bridge current controllers and the shared, bidirectional enable/fault pin of a motor power stage. It watches the overcurrent and short-circuit flags of both bridges, a junction temperature given as an integer in degrees Celsius, and the digitised level of the enable pin. From these it drives the open-drain pull-down of that pin, a single power-stage enable for both bridges, and a three-bit record of what caused the last shutdown.

An overcurrent or short-circuit flag shuts the stage down in the same cycle and pulls the pin low. The pull-down stays on until the pin is seen below a release level; it is then switched off so that an external RC network can recharge the line. The stage comes back only once the pin reads above a logic-high level. Overtemperature uses its own hysteresis: it trips at one temperature and lets go only well below it, and while it is active the pin stays pulled low whatever the overcurrent path does. A host that holds the pin low simply keeps the stage off without any fault being recorded. A low standby input holds all state in reset and keeps both outputs off.

The pin level and the temperature code reach the decision logic through a two-flop synchronizer. The overcurrent flags are taken as synchronous and act without delay.

Top module: `hbridge_fault_supervisor`

## Requirements
- R1: When any of ocFlagA, shortFlagA, ocFlagB, shortFlagB is high (and standbyN is high), stageEnable is 0 and pinPullDown is 1 in the same cycle.
- R2: After an overcurrent or short-circuit event, pinPullDown stays 1 and stageEnable stays 0 until the synchronised pin level is below RELEASE_LVL (default 40); pinPullDown then goes to 0.
- R3: stageEnable returns to 1 only when the synchronised pin level is at least HIGH_LVL (default 160) and no fault is active.
- R4: A synchronised temperature of TRIP_C (default 160) or more sets the thermal fault, which forces stageEnable to 0 and pinPullDown to 1.
- R5: The thermal fault clears only when the synchronised temperature is below TRIP_C minus HYST_C (default 120); between 120 and 159 it keeps its previous state.
- R6: While standbyN is 0, stageEnable and pinPullDown are 0 whatever the other inputs, and faultCause is 0.
- R7: A pin level between RELEASE_LVL and HIGH_LVL driven from outside while the stage runs turns stageEnable to 0 with pinPullDown 0 and faultCause unchanged at 0.
- R8: faultCause is sticky: bit 0 is set by a bridge A flag, bit 1 by a bridge B flag, bit 2 by the thermal fault; it is cleared to 0 on the cycle the stage is re-enabled.
- R9: While the thermal fault is active, the overcurrent release does not free the pin: pinPullDown stays 1 until both are clear.
- R10: The pin level and temperature pass a two-stage synchronizer: a pin change is acted on by the state after the third rising edge, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standbyN | input | 1 | Standby, active low; holds everything in reset |
| ocFlagA | input | 1 | Overcurrent flag, bridge A |
| shortFlagA | input | 1 | Short-circuit flag, bridge A |
| ocFlagB | input | 1 | Overcurrent flag, bridge B |
| shortFlagB | input | 1 | Short-circuit flag, bridge B |
| tempC | input | TEMP_W | Junction temperature, unsigned degrees Celsius |
| pinLevel | input | LVL_W | Digitised level of the shared enable pin |
| pinPullDown | output | 1 | Turns on the open-drain pull-down of the enable pin |
| stageEnable | output | 1 | Power-stage enable for both bridges |
| faultCause | output | 3 | Sticky cause: bit0 bridge A, bit1 bridge B, bit2 thermal |

## Verification
Each result has its own latency: a bridge flag acts on pinPullDown and stageEnable combinationally and on faultCause at the next rising edge; a pin level change moves the state after three edges; a temperature change moves pinPullDown and stageEnable after three edges and faultCause after four. Inputs are changed on the falling edge, and every check either samples one nanosecond later for the combinational cases or waits at least the stated number of edges, with one check placed at two and three edges to pin down the synchronizer depth. The pin and temperature thresholds are swept one code at a time in both directions against a hysteresis model kept in the bench.

// File: rtl/hfs_pkg.sv
package hfs_pkg;

  // status from datapath to control
  typedef struct packed {
    logic ocNow;     // any bridge flag, unsynchronised
    logic thermHot;  // hysteretic thermal fault
    logic pinLow;    // pin below release level
    logic pinHigh;   // pin at or above logic-high level
  } status_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCause;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } state_t;

endpackage

// File: rtl/hfs_datapath.sv
module hfs_datapath
  import hfs_pkg::*;
#(
  parameter int TEMP_W      = 9,
  parameter int LVL_W       = 8,
  parameter int TRIP_C      = 160,
  parameter int HYST_C      = 40,
  parameter int RELEASE_LVL = 40,
  parameter int HIGH_LVL    = 160
) (
  input  logic              clk,
  input  logic              arstN,
  input  logic              ocFlagA,
  input  logic              shortFlagA,
  input  logic              ocFlagB,
  input  logic              shortFlagB,
  input  logic [TEMP_W-1:0] tempC,
  input  logic [LVL_W-1:0]  pinLevel,
  input  strobe_t           strobe,
  output status_t           status,
  output logic [2:0]        faultCause
);

  localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] COOL_CODE = TEMP_W'(TRIP_C - HYST_C);
  localparam logic [LVL_W-1:0]  REL_CODE  = LVL_W'(RELEASE_LVL);
  localparam logic [LVL_W-1:0]  HIGH_CODE = LVL_W'(HIGH_LVL);
  localparam int SYNC_STAGES = 2;

  logic [TEMP_W-1:0] tempPipe [SYNC_STAGES];
  logic [LVL_W-1:0]  lvlPipe  [SYNC_STAGES];
  logic [TEMP_W-1:0] tempSync;
  logic [LVL_W-1:0]  lvlSync;
  logic              thermHot;
  logic              faultA;
  logic              faultB;

  // two-stage synchronizers for the pin level and temperature code
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) begin
          tempPipe[s] <= '0;
          lvlPipe[s]  <= '0;
        end else if (s == 0) begin
          tempPipe[s] <= tempC;
          lvlPipe[s]  <= pinLevel;
        end else begin
          tempPipe[s] <= tempPipe[s-1];
          lvlPipe[s]  <= lvlPipe[s-1];
        end
      end
    end
  endgenerate

  assign tempSync = tempPipe[SYNC_STAGES-1];
  assign lvlSync  = lvlPipe[SYNC_STAGES-1];

  // thermal fault with hysteresis
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      thermHot <= 1'b0;
    end else if (tempSync >= TRIP_CODE) begin
      thermHot <= 1'b1;
    end else if (tempSync < COOL_CODE) begin
      thermHot <= 1'b0;
    end
  end

  assign faultA = ocFlagA | shortFlagA;
  assign faultB = ocFlagB | shortFlagB;

  // sticky cause record, cleared when the stage is re-enabled
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      faultCause <= 3'b000;
    end else if (strobe.clearCause) begin
      faultCause <= 3'b000;
    end else begin
      faultCause <= faultCause | {thermHot, faultB, faultA};
    end
  end

  always_comb begin
    status.ocNow    = faultA | faultB;
    status.thermHot = thermHot;
    status.pinLow   = lvlSync < REL_CODE;
    status.pinHigh  = lvlSync >= HIGH_CODE;
  end

  assert_therm_trip_R4 : assert property (@(posedge clk) disable iff (!arstN)
    (tempSync >= TRIP_CODE) |=> thermHot);

  assert_therm_holds_R5 : assert property (@(posedge clk) disable iff (!arstN)
    (thermHot && tempSync >= COOL_CODE) |=> thermHot);

  assert_therm_stays_cool_R5 : assert property (@(posedge clk) disable iff (!arstN)
    (!thermHot && tempSync < TRIP_CODE) |=> !thermHot);

  assert_cause_cleared_R8 : assert property (@(posedge clk) disable iff (!arstN)
    strobe.clearCause |=> (faultCause == 3'b000));

  assert_cause_sticky_R8 : assert property (@(posedge clk) disable iff (!arstN)
    !strobe.clearCause |=> ((faultCause & $past(faultCause)) == $past(faultCause)));

endmodule

// File: rtl/hfs_control.sv
module hfs_control
  import hfs_pkg::*;
(
  input  logic    clk,
  input  logic    arstN,
  input  logic    active,
  input  status_t status,
  output strobe_t strobe,
  output logic    stageEnable,
  output logic    pinPullDown
);

  state_t state;
  state_t stateNext;

  always_comb begin
    stateNext         = state;
    strobe.clearCause = 1'b0;
    unique case (state)
      ST_WAIT: begin
        if (status.ocNow) begin
          stateNext = ST_HOLD;
        end else if (status.pinHigh && !status.thermHot) begin
          stateNext         = ST_RUN;
          strobe.clearCause = 1'b1;
        end
      end
      ST_RUN: begin
        if (status.ocNow) begin
          stateNext = ST_HOLD;
        end else if (status.thermHot || !status.pinHigh) begin
          stateNext = ST_WAIT;
        end
      end
      ST_HOLD: begin
        if (status.pinLow) begin
          stateNext = ST_WAIT;
        end
      end
      default: stateNext = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      state <= ST_WAIT;
    end else begin
      state <= stateNext;
    end
  end

  assign stageEnable = active && (state == ST_RUN) && !status.ocNow && !status.thermHot;
  assign pinPullDown = active && ((state == ST_HOLD) || status.ocNow || status.thermHot);

  assert_hold_keeps_pull_R2 : assert property (@(posedge clk) disable iff (!arstN)
    (state == ST_HOLD && !status.pinLow) |=> pinPullDown);

  assert_no_enable_without_high_R3 : assert property (@(posedge clk) disable iff (!arstN)
    (state != ST_RUN && !status.pinHigh) |=> !stageEnable);

  assert_hot_blocks_run_R9 : assert property (@(posedge clk) disable iff (!arstN)
    (state != ST_RUN && status.thermHot) |=> (state != ST_RUN));

endmodule

// File: rtl/hbridge_fault_supervisor.sv
module hbridge_fault_supervisor
  import hfs_pkg::*;
#(
  parameter int TEMP_W      = 9,
  parameter int LVL_W       = 8,
  parameter int TRIP_C      = 160,
  parameter int HYST_C      = 40,
  parameter int RELEASE_LVL = 40,
  parameter int HIGH_LVL    = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyN,
  input  logic              ocFlagA,
  input  logic              shortFlagA,
  input  logic              ocFlagB,
  input  logic              shortFlagB,
  input  logic [TEMP_W-1:0] tempC,
  input  logic [LVL_W-1:0]  pinLevel,
  output logic              pinPullDown,
  output logic              stageEnable,
  output logic [2:0]        faultCause
);

  logic    arstN;
  status_t status;
  strobe_t strobe;

  // standby acts as a second asynchronous reset
  assign arstN = rstN & standbyN;

  hfs_datapath #(
    .TEMP_W(TEMP_W), .LVL_W(LVL_W), .TRIP_C(TRIP_C), .HYST_C(HYST_C),
    .RELEASE_LVL(RELEASE_LVL), .HIGH_LVL(HIGH_LVL)
  ) u_dp (
    .clk(clk), .arstN(arstN),
    .ocFlagA(ocFlagA), .shortFlagA(shortFlagA),
    .ocFlagB(ocFlagB), .shortFlagB(shortFlagB),
    .tempC(tempC), .pinLevel(pinLevel),
    .strobe(strobe), .status(status), .faultCause(faultCause)
  );

  hfs_control u_ctl (
    .clk(clk), .arstN(arstN), .active(standbyN),
    .status(status), .strobe(strobe),
    .stageEnable(stageEnable), .pinPullDown(pinPullDown)
  );

  assert_flag_kills_stage_R1 : assert property (@(posedge clk) disable iff (!arstN)
    (ocFlagA || shortFlagA || ocFlagB || shortFlagB) |-> (pinPullDown && !stageEnable));

  always_comb begin
    if (standbyN == 1'b0) begin
      assert_standby_quiet_R6 : assert (!stageEnable && !pinPullDown && faultCause == 3'b000);
    end
  end

endmodule

// File: tb/tb_hbridge_fault_supervisor.sv
module tb_hbridge_fault_supervisor;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       standbyN = 1'b1;
  logic       ocFlagA = 1'b0, shortFlagA = 1'b0, ocFlagB = 1'b0, shortFlagB = 1'b0;
  logic [8:0] tempC = 9'd25;
  logic [7:0] pinLevel = 8'd0;
  logic       pinPullDown, stageEnable;
  logic [2:0] faultCause;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit hotModel = 1'b0;
  bit seenRun;

  always #10 clk = ~clk;

  hbridge_fault_supervisor dut (
    .clk(clk), .rstN(rstN), .standbyN(standbyN),
    .ocFlagA(ocFlagA), .shortFlagA(shortFlagA),
    .ocFlagB(ocFlagB), .shortFlagB(shortFlagB),
    .tempC(tempC), .pinLevel(pinLevel),
    .pinPullDown(pinPullDown), .stageEnable(stageEnable), .faultCause(faultCause)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    // reset state (R6 reset side)
    tick(2);
    chk("R6 reset stageEnable", stageEnable, 0);
    chk("R6 reset pullDown", pinPullDown, 0);
    chk("R6 reset cause", faultCause, 0);
    rstN = 1'b1;

    // start-up: pin high enables the stage (R3)
    pinLevel = 8'd255;
    tick(5);
    chk("R3 startup enable", stageEnable, 1);
    chk("R8 startup cause", faultCause, 0);

    // R10: pin drop acts after three edges, not two
    pinLevel = 8'd100;
    tick(2);
    chk("R10 two edges still enabled", stageEnable, 1);
    tick(1);
    chk("R10 three edges disabled", stageEnable, 0);
    chk("R7 external low no pull", pinPullDown, 0);
    chk("R7 external low no cause", faultCause, 0);
    pinLevel = 8'd255;
    tick(5);
    chk("R7 re-enable after host release", stageEnable, 1);

    // R1 immediate response to bridge A overcurrent
    ocFlagA = 1'b1;
    #1;
    chk("R1 ocA stage off", stageEnable, 0);
    chk("R1 ocA pull on", pinPullDown, 1);
    tick(1);
    ocFlagA = 1'b0;
    chk("R8 cause bridge A", faultCause, 1);
    tick(3);
    chk("R2 pull held while pin high", pinPullDown, 1);

    // R2 sweep pin downward one code at a time
    for (int lvl = 255; lvl >= 0; lvl--) begin
      pinLevel = 8'(lvl);
      tick(4);
      chk("R2 release sweep pull", pinPullDown, (lvl >= 40) ? 1 : 0);
      chk("R2 release sweep stage", stageEnable, 0);
    end
    chk("R8 cause kept while waiting", faultCause, 1);

    // R3 sweep pin upward
    seenRun = 1'b0;
    for (int lvl = 0; lvl <= 255; lvl++) begin
      pinLevel = 8'(lvl);
      tick(4);
      chk("R3 recharge sweep stage", stageEnable, (lvl >= 160) ? 1 : 0);
      chk("R3 recharge sweep pull", pinPullDown, 0);
      if (stageEnable && !seenRun) begin
        seenRun = 1'b1;
        chk("R8 cause cleared on re-enable", faultCause, 0);
      end
    end

    // R1 / R8 bridge B short circuit
    shortFlagB = 1'b1;
    #1;
    chk("R1 scB stage off", stageEnable, 0);
    chk("R1 scB pull on", pinPullDown, 1);
    tick(1);
    shortFlagB = 1'b0;
    chk("R8 cause bridge B", faultCause, 2);
    pinLevel = 8'd0;
    tick(5);
    chk("R2 scB release", pinPullDown, 0);
    pinLevel = 8'd255;
    tick(5);
    chk("R3 scB re-enable", stageEnable, 1);
    chk("R8 cause cleared after B", faultCause, 0);

    // R4 / R5 temperature sweep up then down against a hysteresis model
    for (int t = 100; t <= 200; t++) begin
      tempC = 9'(t);
      if (t >= 160) hotModel = 1'b1;
      else if (t < 120) hotModel = 1'b0;
      tick(5);
      chk("R4 heat sweep pull", pinPullDown, hotModel);
      chk("R4 heat sweep stage", stageEnable, !hotModel);
    end
    chk("R8 cause thermal", faultCause, 4);
    for (int t = 200; t >= 100; t--) begin
      tempC = 9'(t);
      if (t >= 160) hotModel = 1'b1;
      else if (t < 120) hotModel = 1'b0;
      tick(5);
      chk("R5 cool sweep pull", pinPullDown, hotModel);
      chk("R5 cool sweep stage", stageEnable, !hotModel);
    end
    chk("R8 cause cleared after cooling", faultCause, 0);

    // R9 thermal and overcurrent together
    tempC = 9'd170;
    tick(5);
    ocFlagA = 1'b1;
    tick(1);
    ocFlagA = 1'b0;
    pinLevel = 8'd0;
    tick(5);
    chk("R9 pull kept by thermal", pinPullDown, 1);
    chk("R9 stage off", stageEnable, 0);
    chk("R8 cause A and thermal", faultCause, 5);
    tempC = 9'd100;
    tick(5);
    chk("R9 pull released when both clear", pinPullDown, 0);
    pinLevel = 8'd255;
    tick(5);
    chk("R9 stage back", stageEnable, 1);
    chk("R8 cause cleared", faultCause, 0);

    // R6 standby overrides a live fault flag
    standbyN = 1'b0;
    ocFlagA = 1'b1;
    #1;
    chk("R6 standby stage", stageEnable, 0);
    chk("R6 standby pull", pinPullDown, 0);
    tick(3);
    chk("R6 standby cause", faultCause, 0);
    ocFlagA = 1'b0;
    standbyN = 1'b1;
    tick(5);
    chk("R6 wake stage", stageEnable, 1);
    chk("R6 wake cause", faultCause, 0);

    finishRun();
  end

endmodule